// File: doc/BRIEF.md
# Page Cacheability Attribute Output Unit

This unit produces the two cache attribute outputs that accompany every external bus cycle of a processor: a write-through flag and a cache-disable flag. For each cycle it picks where the attributes come from. They come from the page entry of a paged cycle, or from control register 3 for a cycle that is not paged while paging is on. They are forced to zero when paging is off or the core is in real mode. A global cache-disable bit from control register 0 can then force the cache-disable flag high.

The attributes are captured together with the three cycle definition outputs (memory/IO, data/control, write/read) on a single-cycle cycle-start strobe. They stay stable until the next strobe. Three-state pins are modelled as separate value and output-enable signals. The enable drops while the bus is handed away during hold, and while an active-low emulator-present input powers the unit down. A fill-permit output tells the line-fill logic whether the current cycle may fill a cache line.

Top module: `page_attr_unit`

## Requirements
- R1: With paging on, real mode off and a paged cycle, a strobe captures write-through from page entry bit 3 and cache-disable from page entry bit 4.
- R2: With paging on, real mode off and a non-paged cycle, a strobe captures write-through from control register 3 bit 3 and cache-disable from control register 3 bit 4.
- R3: With paging off or real mode on, the page-derived write-through and cache-disable are both zero, whatever the page entry and control register 3 hold.
- R4: When the control register 0 cache-disable input is 1 at a strobe, the captured cache-disable is 1 whatever the source; when it is 0, the source value is passed through.
- R5: On a strobe (cyc_start high, emu_present_n high) the attributes and cyc_def_in are captured and appear on wt_q, cd_q and cyc_def_q one clock later; without a strobe these outputs hold their value.
- R6: Synchronous reset clears wt_q, cd_q and cyc_def_q to zero.
- R7: While hold_ack is 1, pin_oe is 0 in the same cycle; a strobe during hold still updates the captured values.
- R8: While emu_present_n is 0, including during reset, pin_oe is 0 and low_power is 1 in the same cycle, and strobes are ignored (captured values hold).
- R9: fill_ok is the inverse of the captured cache-disable: it is 0 whenever cd_q is 1 and 1 whenever cd_q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_on | input | 1 | Paging enabled |
| real_mode | input | 1 | Core in real mode |
| cyc_paged | input | 1 | Current cycle goes through translation |
| pte_bits | input | 32 | Page entry of the current cycle |
| cr3_bits | input | 32 | Control register 3 |
| cr0_cache_dis | input | 1 | Global cache-disable bit of control register 0 |
| cyc_start | input | 1 | Single-cycle strobe at the start of a bus cycle |
| cyc_def_in | input | 3 | Cycle definition {mem/IO, data/control, write/read} |
| hold_ack | input | 1 | Bus granted away |
| emu_present_n | input | 1 | Active-low emulator present / power-down request |
| wt_q | output | 1 | Write-through value |
| cd_q | output | 1 | Cache-disable value |
| cyc_def_q | output | 3 | Registered cycle definition |
| pin_oe | output | 1 | Output enable of the attribute and cycle definition pins |
| low_power | output | 1 | Power-down state indicator |
| fill_ok | output | 1 | Cache line fill permitted for this cycle |

## Verification
The captured values (wt_q, cd_q, cyc_def_q, fill_ok) are due one clock after the edge that samples the strobe, while pin_oe and low_power follow hold_ack and emu_present_n within the same cycle. The bench drives inputs on the falling edge. At each falling edge it first compares every output against a reference model updated at the previous rising edge. It then applies new inputs and advances the model as the coming rising edge will. Every result is therefore read half a cycle after the edge that produced it.

// File: rtl/cache_attr_pkg.sv
`timescale 1ns/1ps
package cache_attr_pkg;

    parameter int ENTRY_W  = 32;
    parameter int WT_POS   = 3;
    parameter int CD_POS   = 4;
    parameter int CYCDEF_W = 3;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_PAGE = 2'd1,
        SRC_CR3  = 2'd2
    } attr_src_t;

    typedef struct packed {
        logic cd;
        logic wt;
    } attr_t;

    function automatic attr_src_t choose_src(logic paging, logic realm, logic paged);
        if (!paging || realm) return SRC_ZERO;
        if (paged)            return SRC_PAGE;
        return SRC_CR3;
    endfunction

    function automatic attr_t resolve_attr(attr_src_t src, attr_t from_page,
                                           attr_t from_cr3, logic global_cd);
        attr_t a;
        case (src)
            SRC_PAGE: a = from_page;
            SRC_CR3:  a = from_cr3;
            default:  a = '0;
        endcase
        a.cd = a.cd | global_cd;
        return a;
    endfunction

endpackage

// File: rtl/attr_select.sv
`timescale 1ns/1ps
module attr_select
    import cache_attr_pkg::*;
#(
    parameter int W  = ENTRY_W,
    parameter int WB = WT_POS,
    parameter int CB = CD_POS
) (
    input  logic         paging_on,
    input  logic         real_mode,
    input  logic         cyc_paged,
    input  logic [W-1:0] pte_bits,
    input  logic [W-1:0] cr3_bits,
    input  logic         cr0_cache_dis,
    output attr_t        attr_out
);
    attr_t     page_a;
    attr_t     cr3_a;
    attr_src_t src;

    always_comb begin
        page_a.wt = pte_bits[WB];
        page_a.cd = pte_bits[CB];
        cr3_a.wt  = cr3_bits[WB];
        cr3_a.cd  = cr3_bits[CB];
        src       = choose_src(paging_on, real_mode, cyc_paged);
        attr_out  = resolve_attr(src, page_a, cr3_a, cr0_cache_dis);
    end
endmodule

// File: rtl/attr_capture.sv
`timescale 1ns/1ps
module attr_capture
    import cache_attr_pkg::*;
#(
    parameter int CW = CYCDEF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  attr_t         attr_in,
    input  logic [CW-1:0] cyc_in,
    output attr_t         attr_q,
    output logic [CW-1:0] cyc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q <= '0;
            cyc_q  <= '0;
        end else if (load) begin
            attr_q <= attr_in;
            cyc_q  <= cyc_in;
        end
    end

    // R5: no load means every captured value keeps its state
    p_hold_between_loads_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable({attr_q, cyc_q}));
endmodule

// File: rtl/pin_drive.sv
`timescale 1ns/1ps
module pin_drive (
    input  logic hold_ack,
    input  logic emu_present_n,
    input  logic cd_cap,
    output logic pin_oe,
    output logic low_power,
    output logic fill_ok
);
    always_comb begin
        low_power = ~emu_present_n;
        pin_oe    = ~hold_ack & emu_present_n;
        fill_ok   = ~cd_cap;
    end
endmodule

// File: rtl/page_attr_unit.sv
`timescale 1ns/1ps
module page_attr_unit
    import cache_attr_pkg::*;
#(
    parameter int W  = ENTRY_W,
    parameter int CW = CYCDEF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          paging_on,
    input  logic          real_mode,
    input  logic          cyc_paged,
    input  logic [W-1:0]  pte_bits,
    input  logic [W-1:0]  cr3_bits,
    input  logic          cr0_cache_dis,
    input  logic          cyc_start,
    input  logic [CW-1:0] cyc_def_in,
    input  logic          hold_ack,
    input  logic          emu_present_n,
    output logic          wt_q,
    output logic          cd_q,
    output logic [CW-1:0] cyc_def_q,
    output logic          pin_oe,
    output logic          low_power,
    output logic          fill_ok
);
    attr_t next_attr;
    attr_t cap_attr;
    logic  load;

    attr_select #(.W(W)) u_sel (
        .paging_on     (paging_on),
        .real_mode     (real_mode),
        .cyc_paged     (cyc_paged),
        .pte_bits      (pte_bits),
        .cr3_bits      (cr3_bits),
        .cr0_cache_dis (cr0_cache_dis),
        .attr_out      (next_attr)
    );

    assign load = cyc_start & emu_present_n;

    attr_capture #(.CW(CW)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .attr_in (next_attr),
        .cyc_in  (cyc_def_in),
        .attr_q  (cap_attr),
        .cyc_q   (cyc_def_q)
    );

    assign wt_q = cap_attr.wt;
    assign cd_q = cap_attr.cd;

    pin_drive u_pin (
        .hold_ack      (hold_ack),
        .emu_present_n (emu_present_n),
        .cd_cap        (cap_attr.cd),
        .pin_oe        (pin_oe),
        .low_power     (low_power),
        .fill_ok       (fill_ok)
    );

    // R4: global cache-disable at a strobe always yields cd_q high
    p_global_cd_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && emu_present_n && cr0_cache_dis) |=> cd_q);

    // R3: paging off or real mode gives zero write-through
    p_zero_source_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && emu_present_n && (!paging_on || real_mode)) |=>
            (!wt_q && (cd_q == $past(cr0_cache_dis))));

    // R8: during power-down the captured outputs are frozen
    p_powerdown_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !emu_present_n |=> $stable({wt_q, cd_q, cyc_def_q}));

    // R7: a strobe during hold still loads the cycle definition
    p_hold_loads_r7: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && cyc_start && emu_present_n) |=> (cyc_def_q == $past(cyc_def_in)));

    // R9: no fill permitted while cache-disable is captured
    p_no_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && emu_present_n && cr0_cache_dis) |=> !fill_ok);
endmodule

// File: tb/test_page_attr_unit.sv
`timescale 1ns/1ps
module test_page_attr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        paging_on, real_mode, cyc_paged;
    logic [31:0] pte_bits, cr3_bits;
    logic        cr0_cache_dis, cyc_start;
    logic [2:0]  cyc_def_in;
    logic        hold_ack, emu_present_n;
    logic        wt_q, cd_q, pin_oe, low_power, fill_ok;
    logic [2:0]  cyc_def_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic       m_wt, m_cd;
    logic [2:0] m_cyc;
    string      m_tag;

    always #5 clk = ~clk;

    page_attr_unit i_page_attr_unit (
        .clk(clk), .rst(rst), .paging_on(paging_on), .real_mode(real_mode),
        .cyc_paged(cyc_paged), .pte_bits(pte_bits), .cr3_bits(cr3_bits),
        .cr0_cache_dis(cr0_cache_dis), .cyc_start(cyc_start),
        .cyc_def_in(cyc_def_in), .hold_ack(hold_ack),
        .emu_present_n(emu_present_n), .wt_q(wt_q), .cd_q(cd_q),
        .cyc_def_q(cyc_def_q), .pin_oe(pin_oe), .low_power(low_power),
        .fill_ok(fill_ok)
    );

    function automatic logic [1:0] ref_attr(logic pg, logic rm, logic pd,
                                            logic [31:0] pte, logic [31:0] c3, logic gcd);
        logic [1:0] r;
        if (!pg || rm) r = 2'b00;
        else if (pd)   r = {pte[4], pte[3]};
        else           r = {c3[4], c3[3]};
        r[1] = r[1] | gcd;
        return r;
    endfunction

    function automatic string ref_tag(logic pg, logic rm, logic pd, logic gcd);
        if (gcd)       return "R4";
        if (!pg || rm) return "R3";
        if (pd)        return "R1";
        return "R2";
    endfunction

    task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk(m_tag, "wt_q", {3'b0, wt_q}, {3'b0, m_wt});
        chk(m_tag, "cd_q", {3'b0, cd_q}, {3'b0, m_cd});
        chk("R5", "cyc_def_q", {1'b0, cyc_def_q}, {1'b0, m_cyc});
        chk("R9", "fill_ok", {3'b0, fill_ok}, {3'b0, ~m_cd});
        chk(hold_ack ? "R7" : "R8", "pin_oe", {3'b0, pin_oe}, {3'b0, ~hold_ack & emu_present_n});
        chk("R8", "low_power", {3'b0, low_power}, {3'b0, ~emu_present_n});
    endtask

    task automatic advance_model();
        logic [1:0] a;
        if (rst) begin
            m_wt = 0; m_cd = 0; m_cyc = 0; m_tag = "R6";
        end else if (cyc_start && emu_present_n) begin
            a = ref_attr(paging_on, real_mode, cyc_paged, pte_bits, cr3_bits, cr0_cache_dis);
            m_wt = a[0]; m_cd = a[1]; m_cyc = cyc_def_in;
            m_tag = ref_tag(paging_on, real_mode, cyc_paged, cr0_cache_dis);
        end
    endtask

    // one cycle: check current state, apply new inputs, advance model for the coming edge
    task automatic step(logic r, logic pg, logic rm, logic pd, logic [31:0] pte,
                        logic [31:0] c3, logic gcd, logic st, logic [2:0] cd_in,
                        logic hl, logic en);
        @(negedge clk);
        check_outputs();
        rst = r; paging_on = pg; real_mode = rm; cyc_paged = pd;
        pte_bits = pte; cr3_bits = c3; cr0_cache_dis = gcd; cyc_start = st;
        cyc_def_in = cd_in; hold_ack = hl; emu_present_n = en;
        #1;
        chk(hl ? "R7" : "R8", "pin_oe same cycle", {3'b0, pin_oe}, {3'b0, ~hl & en});
        advance_model();
    endtask

    initial begin
        rst = 1; paging_on = 0; real_mode = 0; cyc_paged = 0;
        pte_bits = 0; cr3_bits = 0; cr0_cache_dis = 0; cyc_start = 0;
        cyc_def_in = 0; hold_ack = 0; emu_present_n = 1;
        m_wt = 0; m_cd = 0; m_cyc = 0; m_tag = "R6";
        void'($urandom(32'd4242));

        // R8 during reset: power-down is honoured while reset is held
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R6: reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R1 paged: bit3 set only
        step(0, 1, 0, 1, 32'h0000_0008, 32'h0000_0010, 0, 1, 3'b101, 0, 1);
        step(0, 1, 0, 1, 32'h0000_0010, 32'h0000_0008, 0, 0, 3'b000, 0, 1);
        // R1 paged: bit4 set only
        step(0, 1, 0, 1, 32'h0000_0010, 32'h0000_0008, 0, 1, 3'b010, 0, 1);
        // R2 non-paged uses control register 3
        step(0, 1, 0, 0, 32'h0000_0018, 32'h0000_0008, 0, 1, 3'b011, 0, 1);
        // R3 real mode forces zero
        step(0, 1, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 3'b111, 0, 1);
        // R4 global cache-disable on zero source
        step(0, 0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 3'b100, 0, 1);
        // R7 strobe during hold still captures
        step(0, 1, 0, 1, 32'h0000_0008, 0, 0, 1, 3'b001, 1, 1);
        step(0, 1, 0, 1, 0, 0, 0, 0, 3'b110, 1, 1);
        // R8 strobe during power-down ignored
        step(0, 1, 0, 1, 32'h0000_0018, 0, 1, 1, 3'b111, 0, 0);
        step(0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 1);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 100) < 2,
                 ($urandom % 4) != 0,
                 ($urandom % 8) == 0,
                 $urandom % 2,
                 $urandom, $urandom,
                 ($urandom % 6) == 0,
                 $urandom % 2,
                 3'($urandom),
                 ($urandom % 5) == 0,
                 ($urandom % 10) != 0);
        end
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule